// File: doc/BRIEF.md
# Digit-Serial Binary-Field Multiplier for GF(2^163)

This block multiplies two elements of GF(2^163) held in polynomial basis. Operand B is read one digit of `DIGIT` bits per clock, starting from its least significant digit. Each digit is multiplied into a running sum with operand A, and A is stepped forward by x^DIGIT and folded back below degree 163 in the same cycle. After the last digit, one further cycle folds the wide running sum into a fully reduced 163-bit product.

Two moduli can be selected on each multiplication. One is the pentanomial x^163 + x^7 + x^6 + x^3 + 1. The other is a trinomial x^163 + x^TRI_K + 1, whose middle exponent is fixed when the block is compiled. A caller presents both operands and the modulus select, pulses `start`, and later gets a single-cycle `done` with the product. A larger `DIGIT` lowers the cycle count, at the cost of wider partial-product and fold logic.

Top module: `gf163_digit_mul`

## Requirements
- R1: While reset is active and after it is released, `done` is 0 and `product` is all zeros until the first multiplication completes.
- R2: With `poly_sel` = 0 when the start is taken, `product` equals op_a·op_b mod (x^163 + x^7 + x^6 + x^3 + 1). That modulus has bits 7, 6, 3 and 0 set below the leading term, so its low part is 0xC9.
- R3: With `poly_sel` = 1 when the start is taken, `product` equals op_a·op_b mod (x^163 + x^TRI_K + 1). With the default TRI_K = 29, x·x^162 gives x^29 + 1.
- R4: `done` rises exactly ceil(163/DIGIT) + 1 clock edges after the edge that takes `start`. That is ceil(163/DIGIT) digit cycles plus one final fold cycle.
- R5: `done` stays high for exactly one cycle per multiplication.
- R6: A `start` seen while a multiplication is in progress has no effect. The same holds for changes to `op_a`, `op_b` or `poly_sel` during that time. Only one `done` follows, and it carries the product of the operands taken at the accepted start.
- R7: `product` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R8: Multiplying by the constant 1 returns the other operand unchanged, and a zero operand gives a zero product, for either modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; taken only when idle |
| poly_sel | input | 1 | Modulus select: 0 pentanomial, 1 trinomial |
| op_a | input | 163 | Multiplicand, polynomial basis, bit i is the coefficient of x^i |
| op_b | input | 163 | Multiplier, consumed DIGIT bits per cycle from bit 0 upward |
| product | output | 163 | Reduced product, held until the next completion |
| done | output | 1 | One-cycle completion strobe |

## Verification
On every cycle, the assertions check the timing contract. `done` is a single-cycle pulse, and it arrives at exactly the right distance from an accepted start. There is never a `done` without an accepted start, and `product` never moves outside a `done` cycle. Whether the arithmetic is right can only be shown by the bench scenarios. These compare each result against a bit-serial reference for both moduli, cover the identity and zero cases and the x·x^162 wrap that exposes the modulus, and drive a second start with altered operands in the middle of a multiplication.

// File: rtl/gf163_pkg.sv
package gf163_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RED  = 2'd2
    } mul_state_e;

endpackage

// File: rtl/gf_modsel.sv
// Produces the part of the chosen modulus below its leading term.
module gf_modsel #(
    parameter int M     = 163,
    parameter int TRI_K = 29
) (
    input  logic         sel,
    output logic [M-1:0] rlow
);
    localparam logic [M-1:0] ONE  = M'(1);
    localparam logic [M-1:0] PENT = (ONE << 7) | (ONE << 6) | (ONE << 3) | ONE;
    localparam logic [M-1:0] TRI  = (ONE << TRI_K) | ONE;

    always_comb begin
        rlow = sel ? TRI : PENT;
    end
endmodule

// File: rtl/gf_pp.sv
// Carry-less product of a field element and one DIGIT-bit slice.
module gf_pp #(
    parameter int M     = 163,
    parameter int DIGIT = 16
) (
    input  logic [M-1:0]       a,
    input  logic [DIGIT-1:0]   digit,
    output logic [M+DIGIT-2:0] pp
);
    localparam int W = M + DIGIT - 1;

    logic [W-1:0] row [DIGIT];

    for (genvar j = 0; j < DIGIT; j++) begin : g_row
        assign row[j] = digit[j] ? ({{(DIGIT-1){1'b0}}, a} << j) : '0;
    end

    always_comb begin
        pp = '0;
        for (int j = 0; j < DIGIT; j++) begin
            pp = pp ^ row[j];
        end
    end
endmodule

// File: rtl/gf_fold.sv
// Folds H overflow bits (degree M..M+H-1) back below degree M in one step.
// Needs H - 1 + (degree of rlow) < M.
module gf_fold #(
    parameter int M = 163,
    parameter int H = 16
) (
    input  logic [M+H-1:0] x,
    input  logic [M-1:0]   rlow,
    output logic [M-1:0]   y
);
    logic [M-1:0] term [H];

    for (genvar j = 0; j < H; j++) begin : g_term
        assign term[j] = x[M+j] ? (rlow << j) : '0;
    end

    always_comb begin
        y = x[M-1:0];
        for (int j = 0; j < H; j++) begin
            y = y ^ term[j];
        end
    end
endmodule

// File: rtl/gf163_digit_mul.sv
module gf163_digit_mul
    import gf163_pkg::*;
#(
    parameter int M     = 163,
    parameter int DIGIT = 16,
    parameter int TRI_K = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         poly_sel,
    input  logic [M-1:0] op_a,
    input  logic [M-1:0] op_b,
    output logic [M-1:0] product,
    output logic         done
);
    localparam int NDIG = (M + DIGIT - 1) / DIGIT;
    localparam int BW   = NDIG * DIGIT;
    localparam int AW   = M + DIGIT - 1;
    localparam int CW   = $clog2(NDIG + 1);
    localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

    typedef struct packed {
        mul_state_e    st;
        logic [M-1:0]  a;
        logic [BW-1:0] b;
        logic [AW-1:0] acc;
        logic [CW-1:0] cnt;
        logic          sel;
        logic [M-1:0]  prod;
        logic          done;
    } regs_t;

    regs_t q, d;

    logic [M-1:0]  rlow;
    logic [AW-1:0] pp;
    logic [M-1:0]  a_step;
    logic [M-1:0]  acc_red;

    gf_modsel #(.M(M), .TRI_K(TRI_K)) u_modsel (
        .sel  (q.sel),
        .rlow (rlow)
    );

    gf_pp #(.M(M), .DIGIT(DIGIT)) u_pp (
        .a     (q.a),
        .digit (q.b[DIGIT-1:0]),
        .pp    (pp)
    );

    // A times x^DIGIT, folded back into the field
    gf_fold #(.M(M), .H(DIGIT)) u_fold_a (
        .x    ({q.a, {DIGIT{1'b0}}}),
        .rlow (rlow),
        .y    (a_step)
    );

    // final fold of the wide running sum
    gf_fold #(.M(M), .H(DIGIT-1)) u_fold_acc (
        .x    (q.acc),
        .rlow (rlow),
        .y    (acc_red)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.a        = op_a;
                    d.b        = '0;
                    d.b[M-1:0] = op_b;
                    d.acc      = '0;
                    d.cnt      = '0;
                    d.sel      = poly_sel;
                    d.st       = ST_RUN;
                end
            end
            ST_RUN: begin
                d.acc = q.acc ^ pp;
                d.a   = a_step;
                d.b   = q.b >> DIGIT;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST) begin
                    d.st = ST_RED;
                end
            end
            ST_RED: begin
                d.prod = acc_red;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign product = q.prod;
    assign done    = q.done;
endmodule

// File: rtl/gf163_digit_mul_chk.sv
module gf163_digit_mul_chk #(
    parameter int M     = 163,
    parameter int DIGIT = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [M-1:0] product
);
    localparam int NDIG = (M + DIGIT - 1) / DIGIT;
    localparam logic [15:0] DUE = 16'(NDIG + 1);

    logic        busy_c;
    logic [15:0] cnt_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            cnt_c  <= '0;
        end else if (start && (!busy_c || done)) begin
            busy_c <= 1'b1;
            cnt_c  <= '0;
        end else if (done) begin
            busy_c <= 1'b0;
        end else if (busy_c) begin
            cnt_c <= cnt_c + 16'd1;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_c && cnt_c == DUE));

    // R4
    latency_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_c && cnt_c == DUE) |-> done);

    // R6
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> !done);
endmodule

bind gf163_digit_mul gf163_digit_mul_chk #(.M(M), .DIGIT(DIGIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .product (product)
);

// File: tb/tb_gf163_digit_mul.sv
module tb_gf163_digit_mul;
    localparam int M     = 163;
    localparam int DIGIT = 16;
    localparam int TRI_K = 29;
    localparam int NDIG  = (M + DIGIT - 1) / DIGIT;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         poly_sel = 1'b0;
    logic [M-1:0] op_a = '0;
    logic [M-1:0] op_b = '0;
    logic [M-1:0] product;
    logic         done;

    always #5 clk = ~clk;

    gf163_digit_mul #(.M(M), .DIGIT(DIGIT), .TRI_K(TRI_K)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poly_sel(poly_sel),
        .op_a(op_a), .op_b(op_b), .product(product), .done(done)
    );

    typedef struct {
        logic [M-1:0] exp;
        int unsigned  sc;
        string        tag;
    } item_t;

    item_t       sb [$];
    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    int          npop = 0;
    int          npush = 0;
    logic        prev_done = 1'b0;
    bit          ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b,
                                             input logic s);
        logic [M-1:0] r;
        logic [M-1:0] low;
        low = s ? ((M'(1) << TRI_K) | M'(1)) : M'('hC9);
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            logic c;
            c = r[M-1];
            r = r << 1;
            if (c) r = r ^ low;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] rnd163();
        logic [191:0] t;
        t = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return t[M-1:0];
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                checks++;
                if (done) begin
                    errors++;
                    $display("FAIL R5 done high two cycles: actual 1 expected 0");
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R6 unexpected done: actual product %h expected no result", product);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    checks++;
                    if (product !== it.exp) begin
                        errors++;
                        $display("FAIL %s product: actual %h expected %h", it.tag, product, it.exp);
                    end
                    checks++;
                    if (cyc - it.sc != NDIG + 2) begin
                        errors++;
                        $display("FAIL R4 latency: actual %0d expected %0d", cyc - it.sc - 1, NDIG + 1);
                    end
                    npop++;
                end
            end
        end
        prev_done = done;
    end

    // driver: issues one multiplication and waits for its result
    task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input logic s,
                          input string tag);
        item_t it;
        it.exp = ref_mul(a, b, s);
        it.sc  = cyc;
        it.tag = tag;
        sb.push_back(it);
        npush++;
        op_a = a; op_b = b; poly_sel = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (npop == npush);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [M-1:0] ra;
        logic [M-1:0] rb;
        logic [M-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (done !== 1'b0 || product !== '0) begin
            errors++;
            $display("FAIL R1 in reset: actual done %b product %h expected 0", done, product);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        checks++;
        if (done !== 1'b0 || product !== '0) begin
            errors++;
            $display("FAIL R1 after reset: actual done %b product %h expected 0", done, product);
        end

        // R2/R3 wrap case: x * x^162 = x^163 reduces to the low part of the modulus
        run_op(M'(2), M'(1) << 162, 1'b0, "R2 x*x^162");
        run_op(M'(2), M'(1) << 162, 1'b1, "R3 x*x^162");

        // R8 identity and zero
        for (int s = 0; s < 2; s++) begin
            ra = rnd163();
            run_op(M'(2), M'(1), s[0], "R8 x*1");
            run_op(ra, M'(1), s[0], "R8 a*1");
            run_op(M'(1), ra, s[0], "R8 1*b");
            run_op('0, ra, s[0], "R8 0*b");
            run_op(ra, '0, s[0], "R8 a*0");
        end

        // all-ones operands
        run_op('1, '1, 1'b0, "R2 ones");
        run_op('1, '1, 1'b1, "R3 ones");

        // random operands, both moduli
        for (int i = 0; i < 12; i++) begin
            run_op(rnd163(), rnd163(), 1'b0, "R2 random");
            run_op(rnd163(), rnd163(), 1'b1, "R3 random");
        end

        // R6: second start and operand changes during a multiplication
        ra = rnd163();
        rb = rnd163();
        begin
            item_t it;
            it.exp = ref_mul(ra, rb, 1'b0);
            it.sc  = cyc;
            it.tag = "R6 busy start ignored";
            sb.push_back(it);
            npush++;
        end
        op_a = ra; op_b = rb; poly_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = rnd163(); op_b = rnd163(); poly_sel = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (npop == npush);
        repeat (NDIG + 6) @(negedge clk);
        checks++;
        if (npop != npush || sb.size() != 0) begin
            errors++;
            $display("FAIL R6 result count: actual %0d expected %0d", npop, npush);
        end

        // R7: product holds while inputs move without a start
        held = product;
        for (int i = 0; i < 10; i++) begin
            op_a = rnd163(); op_b = rnd163(); poly_sel = i[0];
            @(negedge clk);
        end
        checks++;
        if (product !== held || done !== 1'b0) begin
            errors++;
            $display("FAIL R7 hold: actual %h expected %h", product, held);
        end

        finish_run();
    end
endmodule